// File: doc/BRIEF.md
# Conference Mixer with Output Gain

This block forms the conference sum for a voice processor that serves eight half-channels in time-multiplexed fashion. Each half-channel owns one 14-bit signed linear sample in a small sample store, written by the surrounding datapath once per frame. Each half-channel also owns a 16-bit configuration word that lists up to three other half-channels to mix in, how many of them are used, and a coarse gain applied to the total.

When the frame strobe arrives, the block walks the channels in ascending order, one per clock. For each channel it adds the channel's own sample to the selected sources, scales the sum by the gain code and clamps the result to the 14-bit range. One mixed sample per channel appears on the output, tagged with its channel number. A done pulse marks the last channel of the frame. Half-channels 0 to 3 carry decoded traffic and 4 to 7 carry traffic to be encoded. Any channel may be named as a source by any other.

Top module: `conf_mixer`

## Requirements
- R1: After reset every channel's configuration word is 0x0000, so mixing is off and the gain is 0 dB. A frame then returns each channel's own sample unchanged.
- R2: The configuration word has this layout: bits 15:14 gain code, bits 13:12 mix mode, bits 11:8 first source, bits 7:4 second source, bits 3:0 third source.
- R3: Mix mode 01 outputs the own sample plus the first source's sample, with gain and clamping applied.
- R4: Mix mode 10 outputs the own sample plus the first and second sources' samples, with gain and clamping applied.
- R5: Mix mode 11 outputs the own sample plus all three sources' samples, with gain and clamping applied.
- R6: Mix mode 00 outputs the own sample alone, and the gain code still applies.
- R7: The gain is applied to the full sum. Code 00 is unity. Code 01 doubles the sum (+6 dB). Code 11 is an arithmetic shift right by one (−6 dB, rounding toward minus infinity). Code 10 is an arithmetic shift right by two (−12 dB).
- R8: A scaled sum above 8191 gives 8191. A scaled sum below −8192 gives −8192.
- R9: A frame strobe taken while idle produces out_valid on the next eight consecutive cycles, with out_ch counting 0 to 7. Each result uses the samples and configuration present in the cycle before it appears.
- R10: done is high exactly in the cycle that carries channel 7.
- R11: A frame strobe that arrives while a frame is running is ignored. The frame ends after channel 7, and no further output follows.
- R12: Only the low three bits of a source field select the channel, so source indices 8 to 15 name channels 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Channel whose configuration word is written |
| cfg_wdata | input | 16 | Configuration word |
| smp_we | input | 1 | Sample write strobe |
| smp_addr | input | 3 | Channel whose sample is written |
| smp_wdata | input | 14 | Signed linear sample |
| frame_start | input | 1 | Starts a mixing pass over all channels |
| out_valid | output | 1 | Mixed sample valid |
| out_ch | output | 3 | Channel of the mixed sample |
| out_sample | output | 14 | Signed mixed, scaled and clamped sample |
| done | output | 1 | High with the last channel of a pass |

## Verification
The clocked checks assume that a channel's configuration word and samples do not change while that channel is being mixed. The pass-through and clamping checks compare the result with the own sample taken one cycle earlier, so they depend on that stability. The bench writes samples and configuration only between passes, and raises a frame strobe inside a running pass only to test that it is ignored. The sweeps step through every mode and gain code. Source fields are scrambled and include values above 7. Sample sets are pseudo-random or built from full-scale extremes, so the clamp is driven in both directions.

// File: rtl/conf_mixer_pkg.sv
package conf_mixer_pkg;

   localparam int SRC_FIELD_W = 4;
   localparam int NUM_SRC     = 3;
   localparam int CFG_W       = 16;

   typedef enum logic [1:0] {
      GAIN_0DB  = 2'b00,
      GAIN_P6DB = 2'b01,
      GAIN_M12DB = 2'b10,
      GAIN_M6DB = 2'b11
   } gain_code_e;

   typedef logic [SRC_FIELD_W-1:0] src_field_t;

   // Packed MSB first: gain, mode, then sources first..third.
   typedef struct packed {
      gain_code_e                 gain;
      logic [1:0]                 mode;
      src_field_t [NUM_SRC-1:0]   src;   // src[2] = first, src[0] = third
   } mix_cfg_t;

endpackage

// File: rtl/conf_cfg_regs.sv
module conf_cfg_regs
   import conf_mixer_pkg::*;
#(
   parameter int NUM_CH = 8,
   localparam int CH_W = $clog2(NUM_CH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [CH_W-1:0]     wr_addr,
   input  logic [CFG_W-1:0]    wr_data,
   input  logic [CH_W-1:0]     rd_addr,
   output mix_cfg_t            rd_cfg
);

   mix_cfg_t cfg_q [NUM_CH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CH; i++) cfg_q[i] <= '0;
      end else if (wr_en) begin
         cfg_q[wr_addr] <= mix_cfg_t'(wr_data);
      end
   end

   assign rd_cfg = cfg_q[rd_addr];

endmodule

// File: rtl/conf_sample_mem.sv
module conf_sample_mem #(
   parameter int NUM_CH   = 8,
   parameter int SAMPLE_W = 14,
   parameter int RD_PORTS = 4,
   localparam int CH_W = $clog2(NUM_CH)
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [CH_W-1:0]                    wr_addr,
   input  logic [SAMPLE_W-1:0]                wr_data,
   input  logic [RD_PORTS-1:0][CH_W-1:0]      rd_addr,
   output logic [RD_PORTS-1:0][SAMPLE_W-1:0]  rd_data
);

   logic [SAMPLE_W-1:0] mem_q [NUM_CH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CH; i++) mem_q[i] <= '0;
      end else if (wr_en) begin
         mem_q[wr_addr] <= wr_data;
      end
   end

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      assign rd_data[p] = mem_q[rd_addr[p]];
   end

endmodule

// File: rtl/conf_mix_core.sv
module conf_mix_core
   import conf_mixer_pkg::*;
#(
   parameter int SAMPLE_W = 14,
   parameter int N_SRC    = 3,
   localparam int ACC_W   = SAMPLE_W + $clog2(N_SRC + 1) + 1,
   localparam int EXT_W   = ACC_W - SAMPLE_W
) (
   input  logic [SAMPLE_W-1:0]             own_smp,
   input  logic [N_SRC-1:0][SAMPLE_W-1:0]  src_smp,   // [0] = first source
   input  logic [1:0]                      mode,
   input  gain_code_e                      gain,
   output logic [SAMPLE_W-1:0]             mixed
);

   localparam logic signed [ACC_W-1:0] SAT_HI =
      {{(EXT_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] SAT_LO = ~SAT_HI;

   logic signed [ACC_W-1:0] term [N_SRC];
   logic signed [ACC_W-1:0] own_ext;
   logic signed [ACC_W-1:0] sum;
   logic signed [ACC_W-1:0] scaled;

   assign own_ext = $signed({{EXT_W{own_smp[SAMPLE_W-1]}}, own_smp});

   // One tap per source; a tap is live when the mode counts past it.
   for (genvar g = 0; g < N_SRC; g++) begin : g_tap
      assign term[g] = (32'(mode) > g)
                     ? $signed({{EXT_W{src_smp[g][SAMPLE_W-1]}}, src_smp[g]})
                     : '0;
   end

   always_comb begin
      sum = own_ext;
      for (int i = 0; i < N_SRC; i++) sum = sum + term[i];
   end

   always_comb begin
      case (gain)
         GAIN_P6DB:  scaled = sum <<< 1;
         GAIN_M6DB:  scaled = sum >>> 1;
         GAIN_M12DB: scaled = sum >>> 2;
         default:    scaled = sum;
      endcase
   end

   always_comb begin
      if (scaled > SAT_HI)      mixed = SAT_HI[SAMPLE_W-1:0];
      else if (scaled < SAT_LO) mixed = SAT_LO[SAMPLE_W-1:0];
      else                      mixed = scaled[SAMPLE_W-1:0];
   end

endmodule

// File: rtl/conf_seq.sv
module conf_seq #(
   parameter int NUM_CH = 8,
   localparam int CH_W = $clog2(NUM_CH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frame_start,
   output logic            busy,
   output logic [CH_W-1:0] cur_ch,
   output logic            out_valid,
   output logic [CH_W-1:0] out_ch,
   output logic            done
);

   localparam logic [CH_W-1:0] LAST = CH_W'(NUM_CH - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         cur_ch    <= '0;
         out_valid <= 1'b0;
         out_ch    <= '0;
         done      <= 1'b0;
      end else begin
         out_valid <= busy;
         out_ch    <= cur_ch;
         done      <= busy && (cur_ch == LAST);
         if (busy) begin
            cur_ch <= cur_ch + 1'b1;
            if (cur_ch == LAST) busy <= 1'b0;
         end else if (frame_start) begin
            busy   <= 1'b1;
            cur_ch <= '0;
         end
      end
   end

   assert_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && frame_start) |=> (busy && cur_ch == '0));

   assert_ch_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ch != LAST) |=> (out_valid && out_ch == $past(out_ch) + 1'b1));

   assert_done_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (out_valid && out_ch == LAST));

   assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cur_ch != LAST) |=> (busy && cur_ch != '0));

endmodule

// File: rtl/conf_mixer.sv
module conf_mixer
   import conf_mixer_pkg::*;
#(
   parameter int NUM_CH   = 8,
   parameter int SAMPLE_W = 14
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cfg_we,
   input  logic [$clog2(NUM_CH)-1:0]   cfg_addr,
   input  logic [CFG_W-1:0]            cfg_wdata,
   input  logic                        smp_we,
   input  logic [$clog2(NUM_CH)-1:0]   smp_addr,
   input  logic [SAMPLE_W-1:0]         smp_wdata,
   input  logic                        frame_start,
   output logic                        out_valid,
   output logic [$clog2(NUM_CH)-1:0]   out_ch,
   output logic [SAMPLE_W-1:0]         out_sample,
   output logic                        done
);

   localparam int CH_W     = $clog2(NUM_CH);
   localparam int RD_PORTS = NUM_SRC + 1;
   localparam logic [SAMPLE_W-1:0] SMP_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};

   initial begin
      assert (NUM_CH >= 2 && (1 << CH_W) == NUM_CH)
         else $fatal(1, "NUM_CH must be a power of two");
      assert (NUM_CH <= (1 << SRC_FIELD_W))
         else $fatal(1, "NUM_CH exceeds source field range");
      assert (SAMPLE_W >= 4 && SAMPLE_W <= 24)
         else $fatal(1, "SAMPLE_W out of range");
   end

   logic                               busy;
   logic [CH_W-1:0]                    cur_ch;
   mix_cfg_t                           cur_cfg;
   logic [RD_PORTS-1:0][CH_W-1:0]      rd_addr;
   logic [RD_PORTS-1:0][SAMPLE_W-1:0]  rd_data;
   logic [NUM_SRC-1:0][SAMPLE_W-1:0]   src_smp;
   logic [SAMPLE_W-1:0]                mixed;

   conf_seq #(.NUM_CH(NUM_CH)) u_seq (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .busy(busy), .cur_ch(cur_ch),
      .out_valid(out_valid), .out_ch(out_ch), .done(done)
   );

   conf_cfg_regs #(.NUM_CH(NUM_CH)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
      .rd_addr(cur_ch), .rd_cfg(cur_cfg)
   );

   // Port 0 reads the own sample, ports 1..NUM_SRC the listed sources.
   assign rd_addr[0] = cur_ch;
   for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      assign rd_addr[k+1] = cur_cfg.src[NUM_SRC-1-k][CH_W-1:0];
      assign src_smp[k]   = rd_data[k+1];
   end

   if (CH_W < SRC_FIELD_W) begin : g_hi_bits
      logic unused_src_hi;
      assign unused_src_hi = ^{cur_cfg.src[0][SRC_FIELD_W-1:CH_W],
                               cur_cfg.src[1][SRC_FIELD_W-1:CH_W],
                               cur_cfg.src[2][SRC_FIELD_W-1:CH_W]};
   end

   conf_sample_mem #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .RD_PORTS(RD_PORTS)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .wr_en(smp_we), .wr_addr(smp_addr), .wr_data(smp_wdata),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   conf_mix_core #(.SAMPLE_W(SAMPLE_W), .N_SRC(NUM_SRC)) u_core (
      .own_smp(rd_data[0]), .src_smp(src_smp),
      .mode(cur_cfg.mode), .gain(cur_cfg.gain), .mixed(mixed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    out_sample <= '0;
      else if (busy) out_sample <= mixed;
   end

   assert_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cur_cfg.mode == 2'b00 && cur_cfg.gain == GAIN_0DB)
      |=> (out_sample == $past(rd_data[0])));

   assert_clamp_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cur_cfg.mode == 2'b00 && cur_cfg.gain == GAIN_P6DB && rd_data[0] == SMP_MAX)
      |=> (out_sample == SMP_MAX));

endmodule

// File: tb/conf_mixer_test.sv
module conf_mixer_test;

   localparam int NCH = 8;
   localparam int SW  = 14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        smp_we = 1'b0;
   logic [2:0]  smp_addr = '0;
   logic [13:0] smp_wdata = '0;
   logic        frame_start = 1'b0;
   logic        out_valid;
   logic [2:0]  out_ch;
   logic [13:0] out_sample;
   logic        done;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   int          m_smp [NCH];
   logic [15:0] m_cfg [NCH];

   always #10 clk = ~clk;   // 50 MHz

   conf_mixer uut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .smp_we(smp_we), .smp_addr(smp_addr), .smp_wdata(smp_wdata),
      .frame_start(frame_start),
      .out_valid(out_valid), .out_ch(out_ch), .out_sample(out_sample), .done(done)
   );

   task automatic chk(string req, string what, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic put_smp(int ch, int v);
      @(negedge clk);
      smp_we = 1'b1; smp_addr = 3'(ch); smp_wdata = 14'(v);
      m_smp[ch] = v;
      @(negedge clk);
      smp_we = 1'b0;
   endtask

   task automatic put_cfg(int ch, logic [15:0] w);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 3'(ch); cfg_wdata = w;
      m_cfg[ch] = w;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Expected value from the requirement text alone.
   function automatic int model(int ch);
      logic [15:0] w = m_cfg[ch];
      int md = int'(w[13:12]);
      int s  = m_smp[ch];
      int r;
      if (md >= 1) s += m_smp[int'(w[10:8])];
      if (md >= 2) s += m_smp[int'(w[6:4])];
      if (md >= 3) s += m_smp[int'(w[2:0])];
      case (w[15:14])
         2'b01:   r = s * 2;
         2'b11:   r = s >>> 1;
         2'b10:   r = s >>> 2;
         default: r = s;
      endcase
      if (r > 8191)  r = 8191;
      if (r < -8192) r = -8192;
      return r;
   endfunction

   // Runs one pass; optional mid-pass strobe at channel slot poke_at.
   task automatic run_frame(string req, int poke_at);
      @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      for (int k = 0; k < NCH; k++) begin
         if (k == poke_at) frame_start = 1'b1;
         @(negedge clk);
         frame_start = 1'b0;
         chk("R9", "out_valid", int'(out_valid), 1);
         chk("R9", "out_ch", int'(out_ch), k);
         chk("R10", "done", int'(done), (k == NCH-1) ? 1 : 0);
         chk(req, $sformatf("ch%0d sample", k), int'($signed(out_sample)), model(k));
      end
      @(negedge clk);
      chk("R11", "idle valid", int'(out_valid), 0);
      chk("R10", "idle done", int'(done), 0);
   endtask

   function automatic int hsh(int a, int b);
      int h = a * 1103515245 + b * 12345 + 977;
      h = h ^ (h >>> 13);
      return h * 2654435 + 31;
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      for (int i = 0; i < NCH; i++) begin m_smp[i] = 0; m_cfg[i] = 16'h0000; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports
      chk("R1", "reset valid", int'(out_valid), 0);
      chk("R1", "reset done", int'(done), 0);
      chk("R1", "reset sample", int'(out_sample), 0);

      // R1: default configuration passes samples through
      for (int i = 0; i < NCH; i++) put_smp(i, (i * 1500) - 5000);
      run_frame("R1", -1);

      // Sweep every mode and gain over two sample patterns (R2 layout).
      for (int pat = 0; pat < 2; pat++) begin
         for (int i = 0; i < NCH; i++) begin
            int v;
            if (pat == 0) v = (hsh(i, 17) & 16383) - 8192;
            else begin
               case (i)
                  0, 2, 3: v = 8191;
                  1, 4, 5: v = -8192;
                  6:       v = 4000;
                  default: v = -1;
               endcase
            end
            put_smp(i, v);
         end
         for (int md = 0; md < 4; md++) begin
            for (int g = 0; g < 4; g++) begin
               string tag;
               case (md)
                  0: tag = "R6";
                  1: tag = "R3";
                  2: tag = "R4";
                  default: tag = "R5";
               endcase
               tag = {tag, " R2 R7 R12"};
               if (pat == 1) tag = {tag, " R8"};
               for (int i = 0; i < NCH; i++) begin
                  int h = hsh(i + 8 * md, g + 4 * pat);
                  put_cfg(i, {2'(g), 2'(md), 4'(h), 4'(h >>> 4), 4'(h >>> 8)});
               end
               run_frame(tag, -1);
            end
         end
      end

      // R12: source index 13 names channel 5, same as index 5
      for (int i = 0; i < NCH; i++) put_cfg(i, 16'h0000);
      for (int i = 0; i < NCH; i++) put_smp(i, 100 * (i + 1));
      put_cfg(0, {2'b00, 2'b01, 4'd13, 4'd0, 4'd0});
      put_cfg(1, {2'b00, 2'b01, 4'd5,  4'd0, 4'd0});
      run_frame("R12", -1);

      // R8: explicit clamp in both directions at +6 dB
      put_smp(2, 5000);
      put_smp(3, -5000);
      put_cfg(2, {2'b01, 2'b00, 12'h000});
      put_cfg(3, {2'b01, 2'b00, 12'h000});
      run_frame("R8", -1);

      // R11: strobe in the middle of a pass is ignored
      run_frame("R11", 3);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule